// File: doc/BRIEF.md
# Dual-Clock 18-Bit FIFO with Programmable Almost-Full Flag

This block is a first-in first-out buffer for 18-bit words. Its write side and read side run on unrelated clocks. Each side has its own enable. Pointers move between the two clock domains as Gray codes through two-flop synchronizers. Three active-low flags come out of the block:

- `fullN`, driven from the write domain.
- `almostFullN`, driven from the write domain. The level at which it trips is set by a loadable offset.
- `emptyN`, driven from the read domain.

The offset is written through the data input using a load strobe. It is read back through the data output using a show strobe.

The block samples two dual-purpose inputs, `wen2` and `ren2`, while reset is held, and they choose one of two operating modes:

- **Standalone:** the two inputs have no effect.
- **Interlocked-parallel:** `wen2` acts as a second write enable and `ren2` as a second read enable. Two such buffers are wired side by side. Each one's `wen2` takes the other's `fullN`, and each one's `ren2` takes the other's `emptyN`. A transfer then happens only when both halves can take part, so the pair stays in step under clock skew.

Top module: `fifoDual`

## Requirements
- R1: Words read out leave on `dout` in the same order they were written, one word per accepted read. `dout` is registered on the read clock.
- R2: `fullN` reads 1 after reset. With no reads, it goes to 0 on the write-clock edge that accepts the DEPTH-th write.
- R3: While `fullN` is 0, no write is stored, whatever the state of `wrEn`.
- R4: `emptyN` reads 0 after reset and again once every stored word has been read. While it is 0, reads are refused and `dout` keeps its last value.
- R5: `almostFullN` goes to 0 when occupancy reaches or exceeds DEPTH minus the offset p. Occupancy here is the write pointer minus the synchronized read pointer. The flag reads 1 otherwise, and p is 7 after reset.
- R6: `wrEn` high together with `offLoadReq` high stores `din[log2(DEPTH)-1:0]` as the new offset p, and that cycle stores no data word.
- R7: `rdEn` high together with `offShowReq` high drives p onto `dout`, with every bit above `log2(DEPTH)-1` driven to 0. No word is removed from the buffer.
- R8: The mode is taken from `wen2` and `ren2` while `rstN` is low.
  - `wen2`=1 with `ren2`=0 selects interlocked-parallel.
  - Every other combination selects standalone, where `wen2` and `ren2` have no effect.
- R9: In interlocked-parallel mode, a write is stored only while `wen2` is 1, and a read is performed only while `ren2` is 1.
- R10: `rstN` low asynchronously clears both pointers and clears `dout` to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wclk | input | 1 | Write clock |
| rclk | input | 1 | Read clock |
| rstN | input | 1 | Asynchronous reset, active low; mode inputs sampled while low |
| wrEn | input | 1 | Write enable |
| offLoadReq | input | 1 | With `wrEn`, load the offset from `din` instead of writing data |
| din | input | 18 | Write data / offset value |
| wen2 | input | 1 | Mode select at reset; second write enable in interlocked mode |
| rdEn | input | 1 | Read enable |
| offShowReq | input | 1 | With `rdEn`, show the offset on `dout` instead of reading data |
| ren2 | input | 1 | Mode select at reset; second read enable in interlocked mode |
| dout | output | 18 | Registered read data / zero-filled offset |
| fullN | output | 1 | Full flag, active low, write domain |
| emptyN | output | 1 | Empty flag, active low, read domain |
| almostFullN | output | 1 | Programmable almost-full flag, active low, write domain |

## Verification
The bench checks the exact write on which `fullN` falls, and then attempts one more write. A design that lost the extra pointer bit would fall one write early or late. A design that let the extra write through would return a stray word at the end of the drain.

The bench moves `almostFullN` across its threshold one word at a time. It does this first with the default offset and then with a reloaded offset. An off-by-one compare, or a load that also pushed a data word, shows up as a wrong flag or as a wrong first word read out.

Reads are attempted on an empty buffer and while `ren2` is low in interlocked mode. A design that popped anyway would change `dout`. In the last part, the bench resets in each mode-select combination and checks that `wen2` and `ren2` gate transfers only in the interlocked mode.

// File: rtl/fifoPkg.sv
package fifoPkg;
  // Per-cycle strobes issued by the control to the datapath.
  // wrPush and offLoad belong to the write clock; rdPop and offShow to the read clock.
  typedef struct packed {
    logic wrPush;
    logic offLoad;
    logic rdPop;
    logic offShow;
  } fifoStrobes_t;
endpackage

// File: rtl/fifoData.sv
module fifoData
  import fifoPkg::*;
#(
  parameter int DATA_W     = 18,
  parameter int AW         = 11,
  parameter int RESET_OFF  = 7
) (
  input  logic              wclk,
  input  logic              rclk,
  input  logic              rstN,
  input  fifoStrobes_t      st,
  input  logic [AW-1:0]     wrAddr,
  input  logic [AW-1:0]     rdAddr,
  input  logic [DATA_W-1:0] din,
  output logic [DATA_W-1:0] dout,
  output logic [AW-1:0]     offVal
);
  localparam int DEPTH = 1 << AW;

  logic [DATA_W-1:0] mem [DEPTH];

  // Storage array: written on the write clock only.
  always_ff @(posedge wclk) begin
    if (st.wrPush) mem[wrAddr] <= din;
  end

  // Programmable offset register (write domain, quasi-static for the read side).
  always_ff @(posedge wclk or negedge rstN) begin
    if (!rstN)           offVal <= AW'(RESET_OFF);
    else if (st.offLoad) offVal <= din[AW-1:0];
  end

  // Output register: the offset takes priority over data, and an idle cycle holds.
  always_ff @(posedge rclk or negedge rstN) begin
    if (!rstN)           dout <= '0;
    else if (st.offShow) dout <= DATA_W'(offVal);
    else if (st.rdPop)   dout <= mem[rdAddr];
  end

  // R7: an offset shown on the output has zero-filled upper bits.
  a_r7_zero_fill: assert property (@(posedge rclk) disable iff (!rstN)
    st.offShow |=> (dout[DATA_W-1:AW] == '0));

  // R4: with no read strobe, the output register holds its value.
  a_r4_dout_hold: assert property (@(posedge rclk) disable iff (!rstN)
    (!st.rdPop && !st.offShow) |=> $stable(dout));
endmodule

// File: rtl/fifoCtrl.sv
module fifoCtrl
  import fifoPkg::*;
#(
  parameter int AW = 11
) (
  input  logic          wclk,
  input  logic          rclk,
  input  logic          rstN,
  input  logic          wrEn,
  input  logic          offLoadReq,
  input  logic          wen2,
  input  logic          rdEn,
  input  logic          offShowReq,
  input  logic          ren2,
  input  logic [AW-1:0] offVal,
  output fifoStrobes_t  st,
  output logic [AW-1:0] wrAddr,
  output logic [AW-1:0] rdAddr,
  output logic          fullN,
  output logic          emptyN,
  output logic          almostFullN
);
  localparam int PW = AW + 1;
  localparam logic [PW-1:0] DEPTH_P = PW'(1 << AW);

  function automatic logic [PW-1:0] toGray(input logic [PW-1:0] b);
    return b ^ (b >> 1);
  endfunction

  function automatic logic [PW-1:0] fromGray(input logic [PW-1:0] g);
    logic [PW-1:0] b;
    b[PW-1] = g[PW-1];
    for (int i = PW - 2; i >= 0; i--) b[i] = b[i+1] ^ g[i];
    return b;
  endfunction

  // Mode capture: loaded on every clock edge while reset is held, then frozen.
  logic parW, parR;
  always_ff @(posedge wclk) if (!rstN) parW <= wen2 & ~ren2;
  always_ff @(posedge rclk) if (!rstN) parR <= wen2 & ~ren2;

  // ---------------- write domain ----------------
  logic [PW-1:0] wrBin, wrGray, wrBinNext, wrGrayNext;
  logic [PW-1:0] rgMeta, rgSync, rdBinSeen, occNext, afLimit;
  logic          wrGo;

  assign wrGo       = wrEn & ~offLoadReq & fullN & (~parW | wen2);
  assign wrBinNext  = wrBin + PW'(wrGo);
  assign wrGrayNext = toGray(wrBinNext);
  assign rdBinSeen  = fromGray(rgSync);
  assign occNext    = wrBinNext - rdBinSeen;
  assign afLimit    = DEPTH_P - PW'(offVal);

  always_ff @(posedge wclk or negedge rstN) begin
    if (!rstN) begin
      rgMeta      <= '0;
      rgSync      <= '0;
      wrBin       <= '0;
      wrGray      <= '0;
      fullN       <= 1'b1;
      almostFullN <= 1'b1;
    end else begin
      rgMeta      <= rdGray;
      rgSync      <= rgMeta;
      wrBin       <= wrBinNext;
      wrGray      <= wrGrayNext;
      fullN       <= !(wrGrayNext == {~rgSync[PW-1:PW-2], rgSync[PW-3:0]});
      almostFullN <= !(occNext >= afLimit);
    end
  end

  // ---------------- read domain ----------------
  logic [PW-1:0] rdBin, rdGray, rdBinNext, rdGrayNext;
  logic [PW-1:0] wgMeta, wgSync;
  logic          rdGo;

  assign rdGo       = rdEn & ~offShowReq & emptyN & (~parR | ren2);
  assign rdBinNext  = rdBin + PW'(rdGo);
  assign rdGrayNext = toGray(rdBinNext);

  always_ff @(posedge rclk or negedge rstN) begin
    if (!rstN) begin
      wgMeta <= '0;
      wgSync <= '0;
      rdBin  <= '0;
      rdGray <= '0;
      emptyN <= 1'b0;
    end else begin
      wgMeta <= wrGray;
      wgSync <= wgMeta;
      rdBin  <= rdBinNext;
      rdGray <= rdGrayNext;
      emptyN <= !(rdGrayNext == wgSync);
    end
  end

  assign st.wrPush  = wrGo;
  assign st.offLoad = wrEn & offLoadReq;
  assign st.rdPop   = rdGo;
  assign st.offShow = rdEn & offShowReq;
  assign wrAddr     = wrBin[AW-1:0];
  assign rdAddr     = rdBin[AW-1:0];

  // R3: a full buffer does not advance its write pointer.
  a_r3_hold_when_full: assert property (@(posedge wclk) disable iff (!rstN)
    !fullN |=> $stable(wrBin));

  // R4: an empty buffer does not advance its read pointer.
  a_r4_hold_when_empty: assert property (@(posedge rclk) disable iff (!rstN)
    !emptyN |=> $stable(rdBin));

  // R2: occupancy seen from the write side never exceeds the depth.
  a_r2_occ_bound: assert property (@(posedge wclk) disable iff (!rstN)
    (wrBin - rdBinSeen) <= DEPTH_P);

  // R2: the full flag falls only on an edge that accepted a write.
  a_r2_full_on_push: assert property (@(posedge wclk) disable iff (!rstN)
    wrGo && ((wrBinNext - rdBinSeen) == DEPTH_P) |=> !fullN);

  // R7: showing the offset leaves the read pointer unchanged.
  a_r7_show_no_pop: assert property (@(posedge rclk) disable iff (!rstN)
    (rdEn && offShowReq) |=> $stable(rdBin));

  // R8: the captured mode stays frozen once reset is released.
  a_r8_mode_frozen: assert property (@(posedge wclk) disable iff (!rstN)
    rstN |=> $stable(parW));
endmodule

// File: rtl/fifoDual.sv
module fifoDual
  import fifoPkg::*;
#(
  parameter int DATA_W       = 18,
  parameter int DEPTH        = 2048,
  parameter int RESET_OFFSET = 7
) (
  input  logic              wclk,
  input  logic              rclk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic              offLoadReq,
  input  logic [DATA_W-1:0] din,
  input  logic              wen2,
  input  logic              rdEn,
  input  logic              offShowReq,
  input  logic              ren2,
  output logic [DATA_W-1:0] dout,
  output logic              fullN,
  output logic              emptyN,
  output logic              almostFullN
);
  localparam int AW = $clog2(DEPTH);

  fifoStrobes_t  st;
  logic [AW-1:0] wrAddr, rdAddr, offVal;

  fifoCtrl #(.AW(AW)) uCtrl (
    .wclk(wclk), .rclk(rclk), .rstN(rstN),
    .wrEn(wrEn), .offLoadReq(offLoadReq), .wen2(wen2),
    .rdEn(rdEn), .offShowReq(offShowReq), .ren2(ren2),
    .offVal(offVal), .st(st), .wrAddr(wrAddr), .rdAddr(rdAddr),
    .fullN(fullN), .emptyN(emptyN), .almostFullN(almostFullN)
  );

  fifoData #(.DATA_W(DATA_W), .AW(AW), .RESET_OFF(RESET_OFFSET)) uData (
    .wclk(wclk), .rclk(rclk), .rstN(rstN), .st(st),
    .wrAddr(wrAddr), .rdAddr(rdAddr), .din(din),
    .dout(dout), .offVal(offVal)
  );
endmodule

// File: tb/sim_fifoDual.sv
module sim_fifoDual;
  localparam int DW = 18;
  localparam int DEPTH = 16;

  logic wclk = 1'b0, rclk = 1'b0, rstN = 1'b0;
  logic wrEn = 1'b0, offLoadReq = 1'b0, wen2 = 1'b0;
  logic rdEn = 1'b0, offShowReq = 1'b0, ren2 = 1'b0;
  logic [DW-1:0] din = '0;
  logic [DW-1:0] dout;
  logic fullN, emptyN, almostFullN;
  int checks = 0, errors = 0;

  always #5 wclk = ~wclk;   // 100 MHz write clock
  always #7 rclk = ~rclk;   // unrelated read clock

  fifoDual #(.DATA_W(DW), .DEPTH(DEPTH), .RESET_OFFSET(7)) u0 (
    .wclk(wclk), .rclk(rclk), .rstN(rstN), .wrEn(wrEn), .offLoadReq(offLoadReq),
    .din(din), .wen2(wen2), .rdEn(rdEn), .offShowReq(offShowReq), .ren2(ren2),
    .dout(dout), .fullN(fullN), .emptyN(emptyN), .almostFullN(almostFullN)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic doReset(input logic w2, input logic r2);
    rstN = 1'b0; wen2 = w2; ren2 = r2;
    repeat (4) @(negedge rclk);
    @(negedge wclk); #2 rstN = 1'b1;
    repeat (2) @(negedge wclk);
  endtask

  task automatic settle();
    repeat (6) @(negedge rclk);
    repeat (6) @(negedge wclk);
  endtask

  task automatic writeWord(input logic [DW-1:0] d);
    @(negedge wclk); wrEn = 1'b1; din = d;
    @(negedge wclk); wrEn = 1'b0;
  endtask

  task automatic popWord();
    @(negedge rclk); rdEn = 1'b1;
    @(negedge rclk); rdEn = 1'b0;
  endtask

  function automatic logic [DW-1:0] pat(input int i);
    return DW'(32'h1A5 * (i + 3) + 32'h20000);
  endfunction

  task automatic testReset();
    doReset(1'b0, 1'b0);
    check("R2 fullN after reset", 32'(fullN), 1);
    check("R4 emptyN after reset", 32'(emptyN), 0);
    check("R5 almostFullN after reset", 32'(almostFullN), 1);
    check("R10 dout after reset", 32'(dout), 0);
  endtask

  task automatic testOrder();
    doReset(1'b0, 1'b0);
    for (int i = 0; i < 5; i++) writeWord(pat(i));
    settle();
    check("R4 emptyN with data", 32'(emptyN), 1);
    for (int i = 0; i < 5; i++) begin
      popWord();
      check("R1 read order", 32'(dout), 32'(pat(i)));
    end
    settle();
    check("R4 emptyN after drain", 32'(emptyN), 0);
    popWord();
    check("R4 dout holds on empty read", 32'(dout), 32'(pat(4)));
  endtask

  task automatic testFull();
    doReset(1'b0, 1'b0);
    for (int i = 0; i < DEPTH - 1; i++) writeWord(pat(i));
    settle();
    check("R2 fullN at DEPTH-1", 32'(fullN), 1);
    writeWord(pat(DEPTH - 1));
    check("R2 fullN at DEPTH", 32'(fullN), 0);
    writeWord(18'h2BEEF);
    check("R3 fullN stays low", 32'(fullN), 0);
    for (int i = 0; i < DEPTH; i++) begin
      popWord();
      if (dout !== pat(i)) check("R3 drain after full", 32'(dout), 32'(pat(i)));
    end
    checks++;
    settle();
    check("R3 empty after DEPTH reads (no extra word)", 32'(emptyN), 0);
    check("R2 fullN released", 32'(fullN), 1);
  endtask

  task automatic testAlmostFull();
    doReset(1'b0, 1'b0);
    for (int i = 0; i < 8; i++) writeWord(pat(i));
    settle();
    check("R5 almostFullN at 8 of 16, p=7", 32'(almostFullN), 1);
    writeWord(pat(8));
    check("R5 almostFullN at 9 of 16, p=7", 32'(almostFullN), 0);
    // Offset load: upper din bits must be ignored, and no data word stored.
    @(negedge wclk); wrEn = 1'b1; offLoadReq = 1'b1; din = 18'h3FFF3;
    @(negedge wclk); wrEn = 1'b0; offLoadReq = 1'b0;
    repeat (2) @(negedge wclk);
    check("R6 almostFullN after p=3 load", 32'(almostFullN), 1);
    for (int i = 9; i < 12; i++) writeWord(pat(i));
    repeat (2) @(negedge wclk);
    check("R6 almostFullN at 12 of 16, p=3", 32'(almostFullN), 1);
    writeWord(pat(12));
    check("R6 almostFullN at 13 of 16, p=3", 32'(almostFullN), 0);
    settle();
    @(negedge rclk); rdEn = 1'b1; offShowReq = 1'b1;
    @(negedge rclk); rdEn = 1'b0; offShowReq = 1'b0;
    check("R7 offset shown zero-filled", 32'(dout), 32'h3);
    popWord();
    check("R7 offset show did not pop", 32'(dout), 32'(pat(0)));
    popWord();
    check("R6 load did not push", 32'(dout), 32'(pat(1)));
  endtask

  task automatic testInterlocked();
    doReset(1'b1, 1'b0);
    wen2 = 1'b0;
    writeWord(18'h11111);
    settle();
    check("R9 write blocked by wen2", 32'(emptyN), 0);
    wen2 = 1'b1;
    writeWord(18'h0ABCD);
    settle();
    check("R9 write with wen2", 32'(emptyN), 1);
    ren2 = 1'b0;
    popWord();
    check("R9 read blocked by ren2", 32'(dout), 0);
    settle();
    check("R9 word kept while ren2 low", 32'(emptyN), 1);
    ren2 = 1'b1;
    popWord();
    check("R9 read with ren2", 32'(dout), 32'h0ABCD);
  endtask

  task automatic testStandaloneIgnore();
    doReset(1'b1, 1'b1);
    wen2 = 1'b0; ren2 = 1'b0;
    writeWord(18'h15A5A);
    settle();
    check("R8 wen2 ignored in standalone", 32'(emptyN), 1);
    popWord();
    check("R8 ren2 ignored in standalone", 32'(dout), 32'h15A5A);
  endtask

  initial begin
    #2_000_000;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    testReset();
    testOrder();
    testFull();
    testAlmostFull();
    testInterlocked();
    testStandaloneIgnore();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule